// File: doc/BRIEF.md
# PWM Timer with Glitch-Free Update Lock

This block is a single-channel pulse-width modulator driven by a small 32-bit register bus. Software programs a period and a duty value, both counted in cycles of the block clock with no prescale. It also picks the level the output takes during the active part of each period and the level it takes for the rest of the period and while stopped. The counter runs from zero up to period minus one and then wraps. The output holds the active level while the count is below the duty value. The output is left-aligned, and the channel repeats period after period for as long as it is enabled.

Software writes only to the programmed registers. The waveform is produced from a second, active set of period, duty and polarity values. The active set is loaded from the programmed set at a period boundary, or at once while the channel is stopped. A lock bit in the control register stops that loading altogether. Software sets the lock, rewrites period, duty and polarity in any order, and then clears the lock. All three new values then start together at the next period boundary, so no period ever mixes old and new settings. A write to the count register moves the running counter, and reading it returns the live count.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset every register reads zero and the output is low.
- R2: Registers are mapped at byte offsets count 0x0, period 0x4, duty 0x8, control 0xC. Period, duty and control read back exactly the last value written. Any other offset reads zero.
- R3: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the counter is held at zero and the output equals the control bit 4 (idle level) as currently programmed.
- R4: While running, the counter steps 0, 1, …, period−1 and then returns to 0. The output is the active level (shadowed bit 3) while count < duty, and the idle level (shadowed bit 4) otherwise.
- R5: While running, a duty value of zero keeps the output at the idle level for the whole period. A duty value at or above the period keeps it at the active level for the whole period.
- R6: With the lock clear and the channel running, new period, duty and polarity values reach the waveform only in the cycle after the counter wraps. They never take effect in the middle of a period.
- R7: With the lock clear and the channel stopped, the active set copies the programmed period, duty and polarity on every clock.
- R8: While control bit 6 (lock) is 1, the active period, duty and polarity do not change, whatever is written and however many boundaries pass.
- R9: After the lock is cleared, the programmed period, duty and polarity all take effect in the same cycle, at the first wrap that follows.
- R10: A write to offset 0x0 while running loads the counter with the written value on the next clock. Reads of offset 0x0 return the live count.
- R11: A period of 0 or 1 makes the counter wrap on every clock, so it stays at 0. The output is then the active level exactly when duty is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the PWM counting clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (4) | Byte offset of the register being accessed |
| busWrite | input | 1 | Write strobe; writes `busWdata` at `busAddr` on the rising edge |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data for `busAddr`, combinational |
| pwmOut | output | 1 | PWM waveform |

## Verification
The bench attacks the moment the lock is released. A design that committed the values on the release write itself, instead of at the next wrap, would show a period cut short, with the new duty applied to the old count. A design that let the lock guard only period and duty would flip polarity mid-period. Unlocked duty writes landing in the middle of a period expose a missing shadow stage as a pulse of the wrong width. Period values of 0 and 1, and duty at zero or above the period, catch off-by-one wrap and compare logic. Counter loads beyond the period check that the wrap still returns the count to zero. Toggling only one of the two enable bits checks that the output falls to the programmed idle level rather than a stale shadowed one.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  // register byte offsets
  localparam int OFS_COUNT  = 'h0;
  localparam int OFS_PERIOD = 'h4;
  localparam int OFS_DUTY   = 'h8;
  localparam int OFS_CTRL   = 'hC;

  // control bit positions
  localparam int BIT_EN     = 0;
  localparam int BIT_CONT   = 1;
  localparam int BIT_ACTHI  = 3;
  localparam int BIT_IDLEHI = 4;
  localparam int BIT_LOCK   = 6;

  // number of shadowed numeric values (period, duty)
  localparam int NUM_SHADOW = 2;
  localparam int IDX_PERIOD = 0;
  localparam int IDX_DUTY   = 1;

  typedef struct packed {
    logic run;      // channel is counting
    logic commit;   // copy programmed values into active set
    logic cntLoad;  // software load of the counter
  } dpStrobe_t;

  typedef struct packed {
    logic activeHi; // level during count < duty
    logic idleHi;   // level otherwise
  } polarity_t;

endpackage

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] cntQ,
  input  logic              wrapHit,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] periodReg,
  output logic [DATA_W-1:0] dutyReg,
  output logic [DATA_W-1:0] ctrlReg,
  output polarity_t         polReg,
  output dpStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] ADR_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] ADR_PERIOD = ADDR_W'(OFS_PERIOD);
  localparam logic [ADDR_W-1:0] ADR_DUTY   = ADDR_W'(OFS_DUTY);
  localparam logic [ADDR_W-1:0] ADR_CTRL   = ADDR_W'(OFS_CTRL);

  logic selCount, selPeriod, selDuty, selCtrl;
  logic runNow, lockNow;

  assign selCount  = busWrite && (busAddr == ADR_COUNT);
  assign selPeriod = busWrite && (busAddr == ADR_PERIOD);
  assign selDuty   = busWrite && (busAddr == ADR_DUTY);
  assign selCtrl   = busWrite && (busAddr == ADR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      dutyReg   <= '0;
      ctrlReg   <= '0;
    end else begin
      if (selPeriod) periodReg <= busWdata;
      if (selDuty)   dutyReg   <= busWdata;
      if (selCtrl)   ctrlReg   <= busWdata;
    end
  end

  assign runNow  = ctrlReg[BIT_EN] & ctrlReg[BIT_CONT];
  assign lockNow = ctrlReg[BIT_LOCK];

  always_comb begin
    polReg.activeHi = ctrlReg[BIT_ACTHI];
    polReg.idleHi   = ctrlReg[BIT_IDLEHI];
    strobe.run      = runNow;
    strobe.commit   = !lockNow && (!runNow || wrapHit);
    strobe.cntLoad  = selCount;
  end

  always_comb begin
    unique case (busAddr)
      ADR_COUNT:  busRdata = cntQ;
      ADR_PERIOD: busRdata = periodReg;
      ADR_DUTY:   busRdata = dutyReg;
      ADR_CTRL:   busRdata = ctrlReg;
      default:    busRdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_shadow_dp.sv
module pwm_shadow_dp
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] periodReg,
  input  logic [DATA_W-1:0] dutyReg,
  input  polarity_t         polReg,
  input  logic [DATA_W-1:0] cntLoadVal,
  output logic [DATA_W-1:0] cntQ,
  output logic              wrapHit,
  output logic [DATA_W-1:0] actPeriod,
  output logic [DATA_W-1:0] actDuty,
  output polarity_t         actPol,
  output logic              pwmOut
);

  localparam logic [DATA_W:0] ONE_WIDE = {{DATA_W{1'b0}}, 1'b1};

  logic [DATA_W-1:0] progVal [NUM_SHADOW];
  logic [DATA_W-1:0] actVal  [NUM_SHADOW];
  logic [DATA_W:0]   cntPlus;
  logic              inDuty;

  assign progVal[IDX_PERIOD] = periodReg;
  assign progVal[IDX_DUTY]   = dutyReg;

  // shadow copies of the numeric settings
  for (genvar gi = 0; gi < NUM_SHADOW; gi++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              actVal[gi] <= '0;
      else if (strobe.commit) actVal[gi] <= progVal[gi];
    end
  end

  assign actPeriod = actVal[IDX_PERIOD];
  assign actDuty   = actVal[IDX_DUTY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              actPol <= '0;
    else if (strobe.commit) actPol <= polReg;
  end

  // wrap when the next count would reach the period (covers period 0 and 1)
  assign cntPlus = {1'b0, cntQ} + ONE_WIDE;
  assign wrapHit = strobe.run && (cntPlus >= {1'b0, actPeriod});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cntQ <= '0;
    else if (!strobe.run)    cntQ <= '0;
    else if (strobe.cntLoad) cntQ <= cntLoadVal;
    else if (wrapHit)        cntQ <= '0;
    else                     cntQ <= cntPlus[DATA_W-1:0];
  end

  assign inDuty = cntQ < actDuty;

  always_comb begin
    if (!strobe.run)  pwmOut = polReg.idleHi;
    else if (inDuty)  pwmOut = actPol.activeHi;
    else              pwmOut = actPol.idleHi;
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              pwmOut
);

  logic [DATA_W-1:0] periodReg, dutyReg, ctrlReg;
  logic [DATA_W-1:0] cntQ, actPeriod, actDuty;
  logic              wrapHit;
  polarity_t         polReg, actPol;
  dpStrobe_t         strobe;

  pwm_shadow_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrite(busWrite), .busWdata(busWdata),
    .cntQ(cntQ), .wrapHit(wrapHit),
    .busRdata(busRdata),
    .periodReg(periodReg), .dutyReg(dutyReg), .ctrlReg(ctrlReg),
    .polReg(polReg), .strobe(strobe)
  );

  pwm_shadow_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .periodReg(periodReg), .dutyReg(dutyReg), .polReg(polReg),
    .cntLoadVal(busWdata),
    .cntQ(cntQ), .wrapHit(wrapHit),
    .actPeriod(actPeriod), .actDuty(actDuty), .actPol(actPol),
    .pwmOut(pwmOut)
  );

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk
  import pwm_shadow_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] ctrlReg,
  input logic [DATA_W-1:0] cntQ,
  input logic              wrapHit,
  input dpStrobe_t         strobe,
  input logic [DATA_W-1:0] actPeriod,
  input logic [DATA_W-1:0] actDuty,
  input polarity_t         actPol,
  input logic              pwmOut
);

  logic runChk;
  assign runChk = ctrlReg[BIT_EN] && ctrlReg[BIT_CONT];

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runChk |-> pwmOut == ctrlReg[BIT_IDLEHI]);

  assert_count_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    !runChk |=> cntQ == '0);

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (runChk && wrapHit && !strobe.cntLoad) |=> cntQ == '0);

  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runChk && actDuty >= actPeriod && cntQ < actPeriod) |-> pwmOut == actPol.activeHi);

  assert_zero_duty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (runChk && actDuty == '0) |-> pwmOut == actPol.idleHi);

  assert_midperiod_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (runChk && !wrapHit) |=> ($stable(actPeriod) && $stable(actDuty) && $stable(actPol)));

  assert_lock_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[BIT_LOCK] |=> ($stable(actPeriod) && $stable(actDuty) && $stable(actPol)));

endmodule

bind pwm_shadow_timer pwm_shadow_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlReg(ctrlReg), .cntQ(cntQ), .wrapHit(wrapHit),
  .strobe(strobe), .actPeriod(actPeriod), .actDuty(actDuty), .actPol(actPol),
  .pwmOut(pwmOut)
);

// File: tb/pwm_shadow_timer_tb.sv
module pwm_shadow_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        pwmOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_shadow_timer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  // reference model built from the requirements
  logic [31:0] mCnt, mPer, mDuty, mCtrl, aPer, aDuty;
  logic        aHi, aIdle;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mPer = 0; mDuty = 0; mCtrl = 0; aPer = 0; aDuty = 0; aHi = 0; aIdle = 0;
    end else begin
      logic run, wrap, commit;
      logic [31:0] nCnt;
      run    = mCtrl[0] && mCtrl[1];
      wrap   = run && (({1'b0, mCnt} + 33'd1) >= {1'b0, aPer});
      commit = !mCtrl[6] && (!run || wrap);
      if (!run) nCnt = 0;
      else if (busWrite && busAddr == 4'h0) nCnt = busWdata;
      else if (wrap) nCnt = 0;
      else nCnt = mCnt + 1;
      if (commit) begin
        aPer = mPer; aDuty = mDuty; aHi = mCtrl[3]; aIdle = mCtrl[4];
      end
      if (busWrite && busAddr == 4'h4) mPer  = busWdata;
      if (busWrite && busAddr == 4'h8) mDuty = busWdata;
      if (busWrite && busAddr == 4'hC) mCtrl = busWdata;
      mCnt = nCnt;
    end
  end

  function automatic logic expOut();
    if (!(mCtrl[0] && mCtrl[1])) return mCtrl[4];
    return (mCnt < aDuty) ? aHi : aIdle;
  endfunction

  function automatic logic [31:0] expRd(logic [3:0] a);
    case (a)
      4'h0: return mCnt;
      4'h4: return mPer;
      4'h8: return mDuty;
      4'hC: return mCtrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    check(tag, "pwmOut", {31'b0, pwmOut}, {31'b0, expOut()});
    check(tag, "busRdata", busRdata, expRd(busAddr));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, string tag);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    tick(tag);
    busWrite = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    busAddr = a;
    #1;
    compareAll(tag);
  endtask

  task automatic idle(int n, logic [3:0] a, string tag);
    busAddr = a;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset values
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");
    rstN = 1'b1;
    tick("R1");

    // R2: map and readback, unmapped offset
    wr(4'h4, 32'd10, "R2"); wr(4'h8, 32'd3, "R2");
    rd(4'h4, "R2"); rd(4'h8, "R2"); rd(4'h1, "R2"); rd(4'h6, "R2");
    wr(4'hC, 32'h0000_0018, "R2"); rd(4'hC, "R2");

    // R3 / R7: stopped channel follows programmed idle level
    wr(4'hC, 32'h0000_0008, "R3"); rd(4'h0, "R3");
    wr(4'hC, 32'h0000_0010, "R3");
    wr(4'hC, 32'h0000_0009, "R3"); idle(4, 4'h0, "R3");
    wr(4'hC, 32'h0000_000A, "R3"); idle(4, 4'h0, "R3");
    wr(4'h4, 32'd7, "R7"); wr(4'h8, 32'd2, "R7"); wr(4'h4, 32'd10, "R7"); wr(4'h8, 32'd3, "R7");

    // R4 / R10: running, left aligned, live count
    wr(4'hC, 32'h0000_000B, "R4");
    idle(25, 4'h0, "R4");

    // R6: unlocked mid-period change
    wr(4'h8, 32'd7, "R6"); idle(12, 4'h0, "R6");
    wr(4'h4, 32'd5, "R6"); wr(4'h8, 32'd2, "R6"); idle(12, 4'h0, "R6");

    // R8: lock holds period, duty and polarity
    wr(4'hC, 32'h0000_004B, "R8");
    wr(4'h4, 32'd6, "R8"); wr(4'h8, 32'd5, "R8");
    idle(9, 4'h0, "R8");
    wr(4'hC, 32'h0000_0053, "R8");
    idle(14, 4'h0, "R8");

    // R9: release lock, all values together at next wrap
    wr(4'hC, 32'h0000_0013, "R9");
    idle(20, 4'h0, "R9");

    // R10: counter loads, including beyond the period
    wr(4'h0, 32'd2, "R10"); idle(8, 4'h0, "R10");
    wr(4'h0, 32'd40, "R10"); idle(8, 4'h0, "R10");

    // R5: duty extremes
    wr(4'hC, 32'h0000_000B, "R5");
    wr(4'h8, 32'd20, "R5"); idle(14, 4'h0, "R5");
    wr(4'h8, 32'd6, "R5");  idle(14, 4'h0, "R5");
    wr(4'h8, 32'd0, "R5");  idle(14, 4'h0, "R5");

    // R11: degenerate periods
    wr(4'h4, 32'd1, "R11"); wr(4'h8, 32'd1, "R11"); idle(8, 4'h0, "R11");
    wr(4'h4, 32'd0, "R11"); idle(8, 4'h0, "R11");
    wr(4'h8, 32'd0, "R11"); idle(8, 4'h0, "R11");

    // R3 / R7: stop, reprogram, restart
    wr(4'hC, 32'h0000_0010, "R3"); idle(3, 4'h0, "R3");
    wr(4'h4, 32'd4, "R7"); wr(4'h8, 32'd1, "R7");
    wr(4'hC, 32'h0000_000B, "R7"); idle(10, 4'h0, "R7");

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [3:0] ra;
      op = $urandom_range(0, 19);
      case ($urandom_range(0, 4))
        0: ra = 4'h0; 1: ra = 4'h4; 2: ra = 4'h8; 3: ra = 4'hC; default: ra = 4'h2;
      endcase
      if (op == 0)      wr(4'h4, $urandom_range(0, 12), "R6");
      else if (op == 1) wr(4'h8, $urandom_range(0, 14), "R6");
      else if (op == 2) wr(4'hC, $urandom & 32'h0000_005B, "R8");
      else if (op == 3) wr(4'hC, 32'h0000_0003 | ($urandom & 32'h0000_0058), "R9");
      else if (op == 4) wr(4'h0, $urandom_range(0, 15), "R10");
      else idle(1, ra, "R4");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule